// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This unit sits in the address stage of a 32-bit load/store pipeline. On each request strobe it forms a single sum: a base value, plus an optional index shifted left by a 2-bit scale code, plus a signed displacement. The sum is registered, so the result appears on the output one clock after the strobe.

A request either targets memory or asks only for the value. In memory mode the registered sum is presented as an address with an address-valid flag. In value-only mode the same sum is presented as a data result with its own valid flag. No memory request is raised, and the unit has no flag-writing output, so nothing in the condition flags can change. An access-size code travels with the request. A request that wants a third register, or wants one register subtracted from another, cannot be encoded as a legal address form. Such a request is rejected with an illegal flag instead of a result.

Top module: `scaled_ea_unit`

## Requirements
- R1: One cycle after a legal request, `ea_o` equals base + (index << scale) + disp, truncated to 32 bits.
- R2: The scale code multiplies the index by 2 raised to the code: 00 gives x1, 01 gives x2, 10 gives x4 and 11 gives x8.
- R3: When `idx_en_i` is 0, the index value and scale code have no effect, and the result is base + disp.
- R4: The displacement is a two's-complement value, so 0xFFFFFFFC subtracts 4 from the sum.
- R5: A sum that exceeds 32 bits wraps modulo 2^32 and raises neither the illegal flag nor any other indication.
- R6: A legal request with `lea_i`=1 gives `res_vld_o`=1 and `addr_vld_o`=0 in the next cycle, with the sum on `ea_o`.
- R7: A request with `third_reg_i`=1 or `reg_sub_i`=1 gives `illegal_o`=1 and both valid outputs 0 in the next cycle.
- R8: `size_o` carries the size code of the latest request (00 = 1 byte, 01 = 2, 10 = 4, 11 = 8 bytes), registered with it.
- R9: A cycle with `req_i`=0 gives `addr_vld_o`, `res_vld_o` and `illegal_o` all 0 in the next cycle.
- R10: While `rst_n` is low, the three outcome flags, `ea_o` and `size_o` are all cleared to 0.
- R11: At most one of `addr_vld_o`, `res_vld_o` and `illegal_o` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Request strobe |
| base_i | input | 32 | Base register value |
| idx_i | input | 32 | Index register value |
| idx_en_i | input | 1 | Index participates in the sum |
| scale_i | input | 2 | Index shift amount |
| disp_i | input | 32 | Signed displacement |
| lea_i | input | 1 | Value-only mode, no memory access |
| size_i | input | 2 | Access size code |
| third_reg_i | input | 1 | Request names a third register |
| reg_sub_i | input | 1 | Request subtracts a register |
| addr_vld_o | output | 1 | Memory address valid |
| res_vld_o | output | 1 | Data result valid (value-only mode) |
| illegal_o | output | 1 | Request rejected |
| ea_o | output | 32 | Registered sum |
| size_o | output | 2 | Registered size code |

## Verification
The four scale codes are applied to one index and one base. This separates a wrong shift amount from an adder fault. An index disabled while it holds a large value and a non-zero scale shows whether the enable truly masks it. A negative displacement and two sums that overflow 32 bits separate sign handling from wrap handling. Value-only requests, both illegal request kinds and idle cycles show the routing of the three outcome flags, while the size code varies from one vector to the next.

// File: rtl/sea_pkg.sv
package sea_pkg;
   typedef enum logic [1:0] {
      KIND_NONE = 2'd0,
      KIND_MEM  = 2'd1,
      KIND_VAL  = 2'd2,
      KIND_BAD  = 2'd3
   } ea_kind_e;
endpackage

// File: rtl/sea_scaler.sv
module sea_scaler #(
   parameter int AW      = 32,
   parameter int SCALE_W = 2,
   parameter bit USE_MUX = 1'b1
) (
   input  logic [AW-1:0]      idx_i,
   input  logic               en_i,
   input  logic [SCALE_W-1:0] sh_i,
   output logic [AW-1:0]      scaled_o
);
   localparam int NSH = 1 << SCALE_W;

   logic [AW-1:0] shifted;

   generate
      if (USE_MUX) begin : g_mux
         logic [AW-1:0] cand [NSH];
         for (genvar k = 0; k < NSH; k++) begin : g_cand
            assign cand[k] = idx_i << k;
         end
         assign shifted = cand[sh_i];
      end else begin : g_barrel
         assign shifted = idx_i << sh_i;
      end
   endgenerate

   assign scaled_o = en_i ? shifted : '0;

   // R3: a disabled index contributes nothing
   always_comb begin
      if (!en_i) assert_idx_masked_R3 : assert (scaled_o == '0);
   end
endmodule

// File: rtl/sea_sum3.sv
module sea_sum3 #(
   parameter int AW = 32
) (
   input  logic [AW-1:0] a_i,
   input  logic [AW-1:0] b_i,
   input  logic [AW-1:0] c_i,
   output logic [AW-1:0] sum_o
);
   logic [AW+1:0] full;
   assign full  = {2'b00, a_i} + {2'b00, b_i} + {2'b00, c_i};
   assign sum_o = full[AW-1:0];
endmodule

// File: rtl/sea_stage.sv
module sea_stage
   import sea_pkg::*;
#(
   parameter int AW  = 32,
   parameter int SZW = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load_i,
   input  ea_kind_e       kind_d,
   input  logic [AW-1:0]  ea_d,
   input  logic [SZW-1:0] size_d,
   output ea_kind_e       kind_q,
   output logic [AW-1:0]  ea_q,
   output logic [SZW-1:0] size_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q <= KIND_NONE;
         ea_q   <= '0;
         size_q <= '0;
      end else begin
         kind_q <= load_i ? kind_d : KIND_NONE;
         if (load_i) begin
            ea_q   <= ea_d;
            size_q <= size_d;
         end
      end
   end

   // R8: size follows the request that loaded the stage
   assert_size_follow_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> size_q == $past(size_d));
endmodule

// File: rtl/scaled_ea_unit.sv
module scaled_ea_unit
   import sea_pkg::*;
#(
   parameter int AW      = 32,
   parameter int SCALE_W = 2,
   parameter int SZW     = 2,
   parameter bit USE_MUX = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_i,
   input  logic [AW-1:0]      base_i,
   input  logic [AW-1:0]      idx_i,
   input  logic               idx_en_i,
   input  logic [SCALE_W-1:0] scale_i,
   input  logic [AW-1:0]      disp_i,
   input  logic               lea_i,
   input  logic [SZW-1:0]     size_i,
   input  logic               third_reg_i,
   input  logic               reg_sub_i,
   output logic               addr_vld_o,
   output logic               res_vld_o,
   output logic               illegal_o,
   output logic [AW-1:0]      ea_o,
   output logic [SZW-1:0]     size_o
);
   localparam int MAX_SH = (1 << SCALE_W) - 1;

   generate
      if (AW < 8)          begin : g_chk_aw  $error("AW too small"); end
      if (SCALE_W < 1)     begin : g_chk_sc  $error("SCALE_W must be positive"); end
      if (MAX_SH >= AW)    begin : g_chk_sh  $error("scale shift exceeds width"); end
   endgenerate

   logic [AW-1:0] scaled;
   logic [AW-1:0] sum;
   logic          bad_req;
   ea_kind_e      kind_d, kind_q;

   sea_scaler #(.AW(AW), .SCALE_W(SCALE_W), .USE_MUX(USE_MUX)) u_scaler (
      .idx_i    (idx_i),
      .en_i     (idx_en_i),
      .sh_i     (scale_i),
      .scaled_o (scaled)
   );

   sea_sum3 #(.AW(AW)) u_sum (
      .a_i   (base_i),
      .b_i   (scaled),
      .c_i   (disp_i),
      .sum_o (sum)
   );

   assign bad_req = third_reg_i | reg_sub_i;

   always_comb begin
      if (bad_req)    kind_d = KIND_BAD;
      else if (lea_i) kind_d = KIND_VAL;
      else            kind_d = KIND_MEM;
   end

   sea_stage #(.AW(AW), .SZW(SZW)) u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (req_i),
      .kind_d (kind_d),
      .ea_d   (sum),
      .size_d (size_i),
      .kind_q (kind_q),
      .ea_q   (ea_o),
      .size_q (size_o)
   );

   assign addr_vld_o = (kind_q == KIND_MEM);
   assign res_vld_o  = (kind_q == KIND_VAL);
   assign illegal_o  = (kind_q == KIND_BAD);

   assert_one_outcome_R11 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({addr_vld_o, res_vld_o, illegal_o}));

   assert_idle_clear_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> !addr_vld_o && !res_vld_o && !illegal_o);

   assert_reject_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      req_i && (third_reg_i || reg_sub_i) |=> illegal_o && !addr_vld_o && !res_vld_o);

   assert_value_only_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      req_i && lea_i && !third_reg_i && !reg_sub_i |=> res_vld_o && !addr_vld_o);

   assert_sum_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      req_i && !third_reg_i && !reg_sub_i && !idx_en_i |=> ea_o == $past(base_i) + $past(disp_i));
endmodule

// File: tb/scaled_ea_unit_tb.sv
module scaled_ea_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic [31:0] base_i = '0, idx_i = '0, disp_i = '0;
   logic        idx_en_i = 1'b0, lea_i = 1'b0, third_reg_i = 1'b0, reg_sub_i = 1'b0;
   logic [1:0]  scale_i = '0, size_i = '0;
   logic        addr_vld_o, res_vld_o, illegal_o;
   logic [31:0] ea_o;
   logic [1:0]  size_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   scaled_ea_unit dut_i (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .base_i(base_i), .idx_i(idx_i),
      .idx_en_i(idx_en_i), .scale_i(scale_i), .disp_i(disp_i), .lea_i(lea_i),
      .size_i(size_i), .third_reg_i(third_reg_i), .reg_sub_i(reg_sub_i),
      .addr_vld_o(addr_vld_o), .res_vld_o(res_vld_o), .illegal_o(illegal_o),
      .ea_o(ea_o), .size_o(size_o)
   );

   typedef struct packed {
      logic [31:0] base;
      logic [31:0] idx;
      logic        en;
      logic [1:0]  sc;
      logic [31:0] disp;
      logic        lea;
      logic [1:0]  sz;
      logic [31:0] exp;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VEC [NV] = '{
      '{32'h0000_1000, 32'h10, 1'b1, 2'd0, 32'h0,         1'b0, 2'd0, 32'h0000_1010}, // R2 x1
      '{32'h0000_1000, 32'h10, 1'b1, 2'd1, 32'h0,         1'b0, 2'd1, 32'h0000_1020}, // R2 x2
      '{32'h0000_1000, 32'h10, 1'b1, 2'd2, 32'h0,         1'b0, 2'd2, 32'h0000_1040}, // R2 x4
      '{32'h0000_1000, 32'h10, 1'b1, 2'd3, 32'h0,         1'b0, 2'd3, 32'h0000_1080}, // R2 x8
      '{32'h0000_2000, 32'hFFFF, 1'b0, 2'd3, 32'h4,       1'b0, 2'd2, 32'h0000_2004}, // R3
      '{32'h0000_0100, 32'h0,  1'b0, 2'd0, 32'hFFFF_FFFC, 1'b0, 2'd1, 32'h0000_00FC}, // R4
      '{32'hFFFF_FFF0, 32'h8,  1'b1, 2'd2, 32'h0,         1'b0, 2'd0, 32'h0000_0010}, // R5
      '{32'h8000_0000, 32'h8000_0000, 1'b1, 2'd0, 32'h8000_0000, 1'b0, 2'd3, 32'h8000_0000}, // R5
      '{32'h0000_0040, 32'h3,  1'b1, 2'd3, 32'h8,         1'b1, 2'd2, 32'h0000_0060}  // R6
   };

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", rq, act, exp);
      end
   endtask

   task automatic chk_flags(input string rq, input logic a, input logic r, input logic i);
      chk({rq, " flags"}, {29'd0, addr_vld_o, res_vld_o, illegal_o}, {29'd0, a, r, i});
      chk("R11 one outcome", {31'd0, $countones({addr_vld_o, res_vld_o, illegal_o}) <= 1}, 32'd1);
   endtask

   task automatic issue(input vec_t v, input logic third, input logic sub);
      @(negedge clk);
      base_i = v.base; idx_i = v.idx; idx_en_i = v.en; scale_i = v.sc;
      disp_i = v.disp; lea_i = v.lea; size_i = v.sz;
      third_reg_i = third; reg_sub_i = sub; req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0; third_reg_i = 1'b0; reg_sub_i = 1'b0;
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk_flags("R10", 1'b0, 1'b0, 1'b0);
      chk("R10 ea", ea_o, 32'h0);
      chk("R10 size", {30'd0, size_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int k = 0; k < NV; k++) begin
         issue(VEC[k], 1'b0, 1'b0);
         chk("R1 ea", ea_o, VEC[k].exp);
         chk("R8 size", {30'd0, size_o}, {30'd0, VEC[k].sz});
         if (VEC[k].lea) chk_flags("R6", 1'b0, 1'b1, 1'b0);
         else            chk_flags("R5 no fault / R1", 1'b1, 1'b0, 1'b0);
      end

      // R9: idle cycle clears every outcome, address held
      @(negedge clk);
      chk_flags("R9", 1'b0, 1'b0, 1'b0);

      // R7: third register requested
      issue(VEC[0], 1'b1, 1'b0);
      chk_flags("R7 third", 1'b0, 1'b0, 1'b1);
      // R7: register subtraction requested, also in value-only mode
      issue(VEC[8], 1'b0, 1'b1);
      chk_flags("R7 sub", 1'b0, 1'b0, 1'b1);
      @(negedge clk);
      chk_flags("R9 after reject", 1'b0, 1'b0, 1'b0);

      // back-to-back requests: each result after one cycle
      @(negedge clk);
      base_i = 32'h10; idx_i = 32'h1; idx_en_i = 1'b1; scale_i = 2'd3; disp_i = 32'h0;
      lea_i = 1'b0; size_i = 2'd1; req_i = 1'b1;
      @(negedge clk);
      chk("R1 first", ea_o, 32'h18);
      base_i = 32'h20; scale_i = 2'd1; size_i = 2'd3;
      @(negedge clk);
      chk("R1 second", ea_o, 32'h22);
      chk("R8 second", {30'd0, size_o}, 32'd3);
      req_i = 1'b0;

      // R10: reset mid-run clears outputs
      rst_n = 1'b0;
      @(negedge clk);
      chk_flags("R10 again", 1'b0, 1'b0, 1'b0);
      chk("R10 ea again", ea_o, 32'h0);
      rst_n = 1'b1;

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule